// File: doc/BRIEF.md
# Signed Bipolar PWM Generator

This block turns a signed duty command into the drive signals for a bridge or servo amplifier. A free-running period timer divides the clock into frames of 2047 cycles, which is about 19.5 kHz from 40 MHz. At each frame boundary the block captures the command together with the output style and pulse shaping. During the frame that follows it emits as many active cycles as the magnitude of the command. The command is two's complement. Zero gives an idle output, and each sign drives its own polarity, so there are 4095 usable levels from full reverse to full forward.

Two output encodings are available. In split mode one line pulses for forward commands and the other for reverse commands. In pulse-plus-sign mode the first line carries the pulses for either sign and the second line holds the sign as a level. The on-time can be sent as a single block at the start of the frame. It can also be spread evenly across the frame by a first-order accumulator, which gives finer ripple. Each output line has its own polarity flip. A monitor line, meant for an indicator lamp, shows the exclusive-or of the two raw drive lines.

Top module: `signed_pwm_gen`

## Requirements
- R1: `cmd_i` is a CMD_W-bit two's complement value. Its magnitude is |cmd| saturated at 2^(CMD_W-1)-1, so the most negative code acts as full-scale reverse. A frame holds exactly that many active drive cycles.
- R2: A frame lasts 2^(CMD_W-1)-1 clock cycles (2047 by default). At full scale the active line stays high for the whole frame.
- R3: The command, `enc_dir_i` and `shape_dens_i` are sampled in the last cycle of a frame and govern all of the next frame. A change during a frame has no effect on that frame. The registered outputs for a frame start one cycle after the frame's first cycle.
- R4: With `shape_dens_i`=0 the active cycles of a frame form one contiguous run, starting at the frame's first output cycle.
- R5: With `enc_dir_i`=0, a positive command pulses `up_o` while `dn_o` stays low. A negative command pulses `dn_o` while `up_o` stays low. Zero keeps both low.
- R6: With `enc_dir_i`=1, `up_o` carries the pulses for either sign. `dn_o` is a constant 1 for a negative command and a constant 0 for zero or positive.
- R7: With `shape_dens_i`=1, a first-order accumulator adds the magnitude every cycle and produces an active cycle on each wrap past the frame length. For magnitudes up to half the frame length, no two active cycles are adjacent.
- R8: `inv_up_i` and `inv_dn_i` each flip their own output line. They take effect on the next clock and do not wait for a frame boundary.
- R9: `mon_o` is the exclusive-or of the raw up and down drive signals, taken before inversion.
- R10: During reset all outputs are 0 and the timer is held at the frame start. The first frame after reset is idle, whatever the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | CMD_W | Signed duty command, two's complement |
| enc_dir_i | input | 1 | 0 = split up/down lines, 1 = pulse line plus sign line |
| shape_dens_i | input | 1 | 0 = one block per frame, 1 = density-spread pulses |
| inv_up_i | input | 1 | Invert `up_o` |
| inv_dn_i | input | 1 | Invert `dn_o` |
| up_o | output | 1 | Forward pulse line, or pulse line in pulse-plus-sign mode |
| dn_o | output | 1 | Reverse pulse line, or sign level |
| mon_o | output | 1 | Raw up XOR raw down, for an indicator |

## Verification
A command presented in any cycle up to the last cycle of frame n-1 is captured at the end of that cycle. Its registered effect then appears in cycles nP+1 through nP+P, counted from the first clock after reset. The bench therefore changes stimulus at falling edges, waits until its own cycle count reaches a multiple of P, and only then samples one full window of P falling edges. It counts active cycles and rising runs over that window. The polarity flips are the only inputs that bypass the frame latch, so they are checked one cycle after the change rather than over a window.

// File: rtl/signed_pwm_pkg.sv
package signed_pwm_pkg;

  typedef enum logic {
    ENC_SPLIT   = 1'b0,
    ENC_PULSDIR = 1'b1
  } enc_e;

  typedef enum logic {
    SHAPE_BLOCK   = 1'b0,
    SHAPE_DENSITY = 1'b1
  } shape_e;

  typedef struct packed {
    enc_e   enc;
    shape_e shape;
    logic   neg;
  } pwm_cfg_t;

endpackage

// File: rtl/pwm_frame_timer.sv
module pwm_frame_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic             frame_end_o
);
  // frame length is 2^CNT_W - 1, so the last count is all ones minus one
  localparam logic [CNT_W-1:0] LAST_CNT = {{(CNT_W-1){1'b1}}, 1'b0};

  logic [CNT_W-1:0] cnt_q;

  assign frame_end_o = (cnt_q == LAST_CNT);
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (frame_end_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_cmd_capture.sv
module pwm_cmd_capture
  import signed_pwm_pkg::*;
#(
  parameter int CMD_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             enc_dir_i,
  input  logic             shape_dens_i,
  output logic [CMD_W-2:0] mag_o,
  output pwm_cfg_t         cfg_o
);
  localparam int MAG_W = CMD_W - 1;
  localparam logic [CMD_W-1:0] LIMIT = {1'b0, {MAG_W{1'b1}}};

  logic             is_neg;
  logic [CMD_W-1:0] abs_val;
  logic [MAG_W-1:0] mag_sat;
  logic [MAG_W-1:0] mag_q;
  pwm_cfg_t         cfg_q;

  assign is_neg  = cmd_i[CMD_W-1];
  // two's complement negate; the most negative code becomes 2^MAG_W
  assign abs_val = is_neg ? (~cmd_i + 1'b1) : cmd_i;
  assign mag_sat = (abs_val > LIMIT) ? LIMIT[MAG_W-1:0] : abs_val[MAG_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q <= '0;
      cfg_q <= '{enc: ENC_SPLIT, shape: SHAPE_BLOCK, neg: 1'b0};
    end else if (load_i) begin
      mag_q     <= mag_sat;
      cfg_q.enc <= enc_dir_i ? ENC_PULSDIR : ENC_SPLIT;
      cfg_q.shape <= shape_dens_i ? SHAPE_DENSITY : SHAPE_BLOCK;
      cfg_q.neg <= is_neg;
    end
  end

  assign mag_o = mag_q;
  assign cfg_o = cfg_q;
endmodule

// File: rtl/pwm_pulse_core.sv
module pwm_pulse_core #(
  parameter int MAG_W       = 11,
  parameter bit HAS_DENSITY = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MAG_W-1:0] cnt_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             dens_i,
  output logic             drive_o
);
  localparam logic [MAG_W:0] FRAME_LEN = {1'b0, {MAG_W{1'b1}}};

  logic block_hit;
  assign block_hit = (cnt_i < mag_i);

  generate
    if (HAS_DENSITY) begin : g_density
      logic [MAG_W-1:0] acc_q;
      logic [MAG_W:0]   acc_sum;
      logic [MAG_W:0]   acc_wrapped;
      logic             dens_hit;

      assign acc_sum     = {1'b0, acc_q} + {1'b0, mag_i};
      assign dens_hit    = (acc_sum >= FRAME_LEN);
      assign acc_wrapped = dens_hit ? (acc_sum - FRAME_LEN) : acc_sum;

      always_ff @(posedge clk) begin
        if (rst) begin
          acc_q <= '0;
        end else if (dens_i) begin
          acc_q <= acc_wrapped[MAG_W-1:0];
        end
      end

      assign drive_o = dens_i ? dens_hit : block_hit;
    end else begin : g_block_only
      logic unused_core;
      assign unused_core = dens_i ^ clk ^ rst;
      assign drive_o     = block_hit;
    end
  endgenerate
endmodule

// File: rtl/pwm_out_encoder.sv
module pwm_out_encoder
  import signed_pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     drive_i,
  input  pwm_cfg_t cfg_i,
  input  logic     inv_up_i,
  input  logic     inv_dn_i,
  output logic     up_o,
  output logic     dn_o,
  output logic     mon_o
);
  logic up_raw;
  logic dn_raw;
  logic unused_cfg;

  assign unused_cfg = cfg_i.shape;

  always_comb begin
    if (cfg_i.enc == ENC_PULSDIR) begin
      up_raw = drive_i;
      dn_raw = cfg_i.neg;
    end else begin
      up_raw = drive_i & ~cfg_i.neg;
      dn_raw = drive_i &  cfg_i.neg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_o  <= 1'b0;
      dn_o  <= 1'b0;
      mon_o <= 1'b0;
    end else begin
      up_o  <= up_raw ^ inv_up_i;
      dn_o  <= dn_raw ^ inv_dn_i;
      mon_o <= up_raw ^ dn_raw;
    end
  end
endmodule

// File: rtl/signed_pwm_gen.sv
module signed_pwm_gen
  import signed_pwm_pkg::*;
#(
  parameter int CMD_W       = 12,
  parameter bit HAS_DENSITY = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             enc_dir_i,
  input  logic             shape_dens_i,
  input  logic             inv_up_i,
  input  logic             inv_dn_i,
  output logic             up_o,
  output logic             dn_o,
  output logic             mon_o
);
  localparam int MAG_W = CMD_W - 1;

  logic [MAG_W-1:0] cnt_q;
  logic             frame_end;
  logic [MAG_W-1:0] mag_q;
  pwm_cfg_t         cfg_q;
  logic             drive;

  pwm_frame_timer #(.CNT_W(MAG_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .cnt_o      (cnt_q),
    .frame_end_o(frame_end)
  );

  pwm_cmd_capture #(.CMD_W(CMD_W)) u_capture (
    .clk         (clk),
    .rst         (rst),
    .load_i      (frame_end),
    .cmd_i       (cmd_i),
    .enc_dir_i   (enc_dir_i),
    .shape_dens_i(shape_dens_i),
    .mag_o       (mag_q),
    .cfg_o       (cfg_q)
  );

  pwm_pulse_core #(.MAG_W(MAG_W), .HAS_DENSITY(HAS_DENSITY)) u_core (
    .clk    (clk),
    .rst    (rst),
    .cnt_i  (cnt_q),
    .mag_i  (mag_q),
    .dens_i (cfg_q.shape == SHAPE_DENSITY),
    .drive_o(drive)
  );

  pwm_out_encoder u_enc (
    .clk     (clk),
    .rst     (rst),
    .drive_i (drive),
    .cfg_i   (cfg_q),
    .inv_up_i(inv_up_i),
    .inv_dn_i(inv_dn_i),
    .up_o    (up_o),
    .dn_o    (dn_o),
    .mon_o   (mon_o)
  );
endmodule

// File: rtl/signed_pwm_chk.sv
module signed_pwm_chk
  import signed_pwm_pkg::*;
#(
  parameter int MAG_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic [MAG_W-1:0] cnt_q,
  input logic [MAG_W-1:0] mag_q,
  input pwm_cfg_t         cfg_q,
  input logic             inv_up_i,
  input logic             inv_dn_i,
  input logic             up_o,
  input logic             dn_o,
  input logic             mon_o
);
  localparam logic [MAG_W-1:0] ALL_ONES = {MAG_W{1'b1}};
  localparam logic [MAG_W-1:0] LAST_CNT = {{(MAG_W-1){1'b1}}, 1'b0};

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q != ALL_ONES); // R2

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    armed && $past(cnt_q) == LAST_CNT |-> cnt_q == '0); // R2

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
    armed && cnt_q != '0 |-> $stable(mag_q) && $stable(cfg_q)); // R3

  AST_SPLIT_EXCL: assert property (@(posedge clk) disable iff (rst)
    armed && $past(cfg_q.enc) == ENC_SPLIT && !$past(inv_up_i) && !$past(inv_dn_i)
    |-> !(up_o && dn_o)); // R5

  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
    armed && $past(mag_q) == '0
    |-> mon_o == 1'b0 && up_o == $past(inv_up_i) && dn_o == $past(inv_dn_i)); // R5

  AST_SIGN_LEVEL: assert property (@(posedge clk) disable iff (rst)
    armed && $past(cfg_q.enc) == ENC_PULSDIR
    |-> dn_o == ($past(cfg_q.neg) ^ $past(inv_dn_i))); // R6

  AST_MON_XOR: assert property (@(posedge clk) disable iff (rst)
    armed |-> mon_o == (up_o ^ dn_o ^ $past(inv_up_i) ^ $past(inv_dn_i))); // R9

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !up_o && !dn_o && !mon_o && cnt_q == '0); // R10
endmodule

bind signed_pwm_gen signed_pwm_chk #(.MAG_W(MAG_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cnt_q   (cnt_q),
  .mag_q   (mag_q),
  .cfg_q   (cfg_q),
  .inv_up_i(inv_up_i),
  .inv_dn_i(inv_dn_i),
  .up_o    (up_o),
  .dn_o    (dn_o),
  .mon_o   (mon_o)
);

// File: tb/tb_signed_pwm_gen.sv
module tb_signed_pwm_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 6;
  localparam int P  = (1 << (CW - 1)) - 1;
  localparam int NV = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] cmd = '0;
  logic dirm = 1'b0, densm = 1'b0, iu = 1'b0, id = 1'b0;
  logic up, dn, mon;

  signed_pwm_gen #(.CMD_W(CW), .HAS_DENSITY(1'b1)) dut (
    .clk(clk), .rst(rst), .cmd_i(cmd), .enc_dir_i(dirm), .shape_dens_i(densm),
    .inv_up_i(iu), .inv_dn_i(id), .up_o(up), .dn_o(dn), .mon_o(mon)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  int n_chk = 0, n_fail = 0;
  int c_up, c_dn, c_mon, r_up, r_dn;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [CW-1:0] cmd;
    logic dm, ds, iu, id;
    logic [7:0] eu, ed, em, ru, rd;
  } vec_t;

  // counts and rising runs over one full output window of P cycles
  localparam vec_t VECS [NV] = '{
    '{CW'(10),  1'b0, 1'b0, 1'b0, 1'b0, 8'd10, 8'd0,  8'd10, 8'd1,  8'd0},
    '{CW'(-7),  1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd7,  8'd7,  8'd0,  8'd1},
    '{CW'(0),   1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd0,  8'd0,  8'd0,  8'd0},
    '{CW'(31),  1'b0, 1'b0, 1'b0, 1'b0, 8'd31, 8'd0,  8'd31, 8'd1,  8'd0},
    '{CW'(-32), 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd31, 8'd31, 8'd0,  8'd1},
    '{CW'(12),  1'b1, 1'b0, 1'b0, 1'b0, 8'd12, 8'd0,  8'd12, 8'd1,  8'd0},
    '{CW'(-5),  1'b1, 1'b0, 1'b0, 1'b0, 8'd5,  8'd31, 8'd26, 8'd1,  8'd1},
    '{CW'(0),   1'b1, 1'b0, 1'b0, 1'b0, 8'd0,  8'd0,  8'd0,  8'd0,  8'd0},
    '{CW'(9),   1'b0, 1'b1, 1'b0, 1'b0, 8'd9,  8'd0,  8'd9,  8'd9,  8'd0},
    '{CW'(-13), 1'b0, 1'b1, 1'b0, 1'b0, 8'd0,  8'd13, 8'd13, 8'd0,  8'd13},
    '{CW'(10),  1'b0, 1'b0, 1'b1, 1'b0, 8'd21, 8'd0,  8'd10, 8'd1,  8'd0},
    '{CW'(-7),  1'b0, 1'b0, 1'b0, 1'b1, 8'd0,  8'd24, 8'd7,  8'd0,  8'd1},
    '{CW'(15),  1'b1, 1'b1, 1'b0, 1'b0, 8'd15, 8'd0,  8'd15, 8'd15, 8'd0}
  };

  function automatic string vtag(input int k);
    case (k)
      0, 1, 2: return "R5";
      3:       return "R2/R5";
      4:       return "R1/R5";
      5, 6, 7: return "R6";
      8, 9:    return "R7";
      10, 11:  return "R8";
      default: return "R6/R7";
    endcase
  endfunction

  // present stimulus, then stop at the first cycle whose index is a multiple of P
  task automatic apply(input logic [CW-1:0] c, input logic m, input logic s,
                       input logic a, input logic b);
    @(negedge clk);
    cmd = c; dirm = m; densm = s; iu = a; id = b;
    @(negedge clk);
    while (cyc % P != 0) @(negedge clk);
  endtask

  // samples cycles nP+1 .. nP+P; optionally changes the command mid-window
  task automatic measure(input int chg_at, input logic [CW-1:0] chg_cmd);
    logic pu, pd;
    c_up = 0; c_dn = 0; c_mon = 0; r_up = 0; r_dn = 0; pu = 1'b0; pd = 1'b0;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      if (up) c_up++;
      if (dn) c_dn++;
      if (mon) c_mon++;
      if (up && (i == 0 || !pu)) r_up++;
      if (dn && (i == 0 || !pd)) r_dn++;
      pu = up; pd = dn;
      if (i == chg_at) cmd = chg_cmd;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R10: reset state, command already present
    cmd = CW'(20);
    repeat (5) @(negedge clk);
    check("R10 up in reset", int'(up), 0);
    check("R10 dn in reset", int'(dn), 0);
    check("R10 mon in reset", int'(mon), 0);
    rst = 1'b0;
    measure(-1, '0);
    check("R10 first frame idle", c_up, 0);
    measure(-1, '0);
    check("R3 command captured at first boundary", c_up, 20);
    check("R4 single run", r_up, 1);

    // table of vectors
    for (int k = 0; k < NV; k++) begin
      apply(VECS[k].cmd, VECS[k].dm, VECS[k].ds, VECS[k].iu, VECS[k].id);
      measure(-1, '0);
      check($sformatf("%s up count vec %0d", vtag(k), k), c_up, int'(VECS[k].eu));
      check($sformatf("%s dn count vec %0d", vtag(k), k), c_dn, int'(VECS[k].ed));
      check($sformatf("R9 mon count vec %0d", k), c_mon, int'(VECS[k].em));
      check($sformatf("%s up runs vec %0d", VECS[k].ds ? "R7" : "R4", k), r_up, int'(VECS[k].ru));
      check($sformatf("%s dn runs vec %0d", VECS[k].ds ? "R7" : "R4", k), r_dn, int'(VECS[k].rd));
    end

    // R3: mid-frame change waits for the boundary
    apply(CW'(8), 1'b0, 1'b0, 1'b0, 1'b0);
    measure(15, CW'(25));
    check("R3 mid-frame change ignored", c_up, 8);
    measure(-1, '0);
    check("R3 change applied next frame", c_up, 25);

    // R8: inversion acts on the next clock, not at the frame boundary
    apply(CW'(0), 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    check("R8 up before invert", int'(up), 0);
    iu = 1'b1;
    @(negedge clk);
    check("R8 up one cycle after invert", int'(up), 1);
    id = 1'b1;
    @(negedge clk);
    check("R8 dn one cycle after invert", int'(dn), 1);
    check("R9 mon unaffected by invert", int'(mon), 0);
    iu = 1'b0; id = 1'b0;
    @(negedge clk);
    check("R8 up restored", int'(up), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule